// File: doc/BRIEF.md
# Per-Group Warp Barrier Tracker

This block sits beside the warp scheduler of one multiprocessor and keeps a separate barrier context for each thread group resident on it. When a group launches, its slot is loaded with the group's thread count; the block converts that to a number of warps, and a partial warp counts as a whole one. Whenever a warp executes the barrier instruction, the decoder presents one arrival carrying the group slot and the warp id. The block marks that warp as held in a stall mask that the scheduler uses to skip it.

Once the last expected warp of a slot has arrived, the block releases the slot. All of that slot's held warps leave the mask together, and the slot's bit on the release vector pulses for one cycle. The slot is then ready for the group's next barrier. Loading a slot with a thread count of zero marks the group as ended. This empties the slot and frees any warps it still holds, without a release pulse.

Both input ports use a valid/ready handshake. The block never applies back-pressure: each ready output is high in every cycle, including during reset, so a beat transfers in any cycle its valid is high. At most one configure beat and one arrival beat are taken per cycle. The stall mask, the release vector and the error flag are plain registered outputs.

Top module: `grp_barrier_unit`

## Requirements
- R1: A configure beat with a nonzero thread count T sets the slot's expected warp count to ceil(T/32), capped at 16, so 33 threads need 2 warps, 32 need 1 and 512 need 16. Any old arrivals in that slot are discarded.
- R2: An accepted arrival of warp w sets bit w of `stall_mask` from the next clock edge. The bit stays set until its slot releases or is emptied.
- R3: The arrival that brings a slot's count up to its expected count takes effect at the next edge, all in that same edge: bit s of `release_pulse` goes high for exactly one cycle, every stall bit held by slot s clears, and the slot's count returns to zero. The final warp's own stall bit never sets, and the slot can then run another barrier.
- R4: Slots are independent. Arrivals at one slot never change the count, the stall bits or the release of another slot, and at most one `release_pulse` bit is high in any cycle.
- R5: An arrival for a warp already held by the same slot is ignored (count and mask unchanged), and `arrive_err` pulses high for one cycle at the next edge.
- R6: An arrival at a slot with no active group (expected count zero), or one with a warp id of 24 or more, is ignored and pulses `arrive_err` at the next edge.
- R7: A configure beat with a thread count of zero ends the group. At the next edge the slot becomes inactive and every stall bit it held clears, with no release pulse.
- R8: When a configure beat and an arrival address the same slot in the same cycle, the configure beat wins. The arrival is dropped without an error.
- R9: `cfg_ready` and `arr_ready` are high in every cycle.
- R10: After reset, `stall_mask`, `release_pulse` and `arrive_err` are all zero and every slot is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configure beat present |
| cfg_ready | output | 1 | Configure beat accepted (always high) |
| cfg_slot | input | 3 | Group slot being configured |
| cfg_threads | input | 10 | Thread count of the group; zero ends it |
| arr_valid | input | 1 | Barrier arrival beat present |
| arr_ready | output | 1 | Arrival accepted (always high) |
| arr_slot | input | 3 | Group slot of the arriving warp |
| arr_warp | input | 5 | Id of the arriving warp |
| stall_mask | output | 24 | Bit w set while warp w waits at a barrier |
| release_pulse | output | 8 | Bit s pulses for one cycle when slot s releases |
| arrive_err | output | 1 | One-cycle pulse for a rejected arrival |

## Verification
The bench builds the block with its default parameters: 8 slots, 24 resident warps, warps of 32 threads and a 512-thread ceiling per group. With these values a single group can fill 16 warps, which exercises the widest count and the cap on the expected count. Every slot index up to the last one, 7, can be reached. A warp id of 24 to 31 fits in the 5-bit field but names no warp, so the range rejection can be driven directly at the port.

// File: rtl/gbu_pkg.sv
package gbu_pkg;
  // whole warps needed for a thread count, limited to a ceiling
  function automatic int unsigned warps_needed(int unsigned threads,
                                               int unsigned lanes,
                                               int unsigned cap);
    int unsigned w;
    w = (threads + lanes - 1) / lanes;
    return (w > cap) ? cap : w;
  endfunction
endpackage

// File: rtl/gbu_slot_ctx.sv
module gbu_slot_ctx #(
  parameter int unsigned WARPS  = 24,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned WARP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hit,
  input  logic [CNT_W-1:0]  cfg_warps,
  input  logic              arr_hit,
  input  logic [WARP_W-1:0] arr_warp,
  output logic [WARPS-1:0]  held,
  output logic              release_q,
  output logic              reject
);
  logic [CNT_W-1:0] need_q, cnt_q, cnt_nx;
  logic [WARPS-1:0] held_q;
  logic             rel_q, live, seen, take;

  assign live   = (need_q != '0);
  assign seen   = held_q[arr_warp];
  assign take   = arr_hit && !cfg_hit && live && !seen;
  assign reject = arr_hit && !cfg_hit && (!live || seen);
  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q <= '0;
      cnt_q  <= '0;
      held_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      if (cfg_hit) begin
        need_q <= cfg_warps;
        cnt_q  <= '0;
        held_q <= '0;
      end else if (take) begin
        if (cnt_nx == need_q) begin
          cnt_q  <= '0;
          held_q <= '0;
          rel_q  <= 1'b1;
        end else begin
          cnt_q            <= cnt_nx;
          held_q[arr_warp] <= 1'b1;
        end
      end
    end
  end

  assign held      = held_q;
  assign release_q = rel_q;

  AST_COUNT_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(held_q) == int'(cnt_q)); // R2
  AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> (held_q == '0 && cnt_q == '0)); // R3
  AST_COUNT_BELOW_NEED: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (cnt_q < need_q)); // R5
  AST_IDLE_HOLDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (held_q == '0)); // R7
  AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (held_q == '0 && !rel_q)); // R8
endmodule

// File: rtl/gbu_mask_merge.sv
module gbu_mask_merge #(
  parameter int unsigned SRCS  = 8,
  parameter int unsigned WIDTH = 24
) (
  input  logic [SRCS-1:0][WIDTH-1:0] masks,
  output logic [WIDTH-1:0]           merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < int'(SRCS); i++) merged = merged | masks[i];
  end
endmodule

// File: rtl/grp_barrier_unit.sv
module grp_barrier_unit #(
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned NUM_WARPS   = 24,
  parameter int unsigned WARP_SIZE   = 32,
  parameter int unsigned MAX_THREADS = 512,
  localparam int unsigned MAX_WARPS  = MAX_THREADS / WARP_SIZE,
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS),
  localparam int unsigned WARP_W     = $clog2(NUM_WARPS),
  localparam int unsigned CNT_W      = $clog2(MAX_WARPS + 1),
  localparam int unsigned THR_W      = $clog2(MAX_THREADS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [THR_W-1:0]     cfg_threads,
  input  logic                 arr_valid,
  output logic                 arr_ready,
  input  logic [SLOT_W-1:0]    arr_slot,
  input  logic [WARP_W-1:0]    arr_warp,
  output logic [NUM_WARPS-1:0] stall_mask,
  output logic [NUM_SLOTS-1:0] release_pulse,
  output logic                 arrive_err
);
  import gbu_pkg::*;

  logic [CNT_W-1:0]                  cfg_warps;
  logic                              warp_ok;
  logic [NUM_SLOTS-1:0]              rej_vec;
  logic [NUM_SLOTS-1:0][NUM_WARPS-1:0] held_vec;
  logic                              err_q;

  assign cfg_ready = 1'b1;
  assign arr_ready = 1'b1;
  assign cfg_warps = CNT_W'(warps_needed(int'(cfg_threads), WARP_SIZE, MAX_WARPS));
  assign warp_ok   = (int'(arr_warp) < int'(NUM_WARPS));

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
    gbu_slot_ctx #(.WARPS(NUM_WARPS), .CNT_W(CNT_W), .WARP_W(WARP_W)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_hit   (cfg_valid && cfg_slot == SLOT_W'(s)),
      .cfg_warps (cfg_warps),
      .arr_hit   (arr_valid && warp_ok && arr_slot == SLOT_W'(s)),
      .arr_warp  (arr_warp),
      .held      (held_vec[s]),
      .release_q (release_pulse[s]),
      .reject    (rej_vec[s])
    );
  end

  gbu_mask_merge #(.SRCS(NUM_SLOTS), .WIDTH(NUM_WARPS)) u_merge (
    .masks  (held_vec),
    .merged (stall_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (arr_valid && !warp_ok) || (|rej_vec);
  end
  assign arrive_err = err_q;

  AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_pulse)); // R4
  AST_ERR_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !arr_valid) |=> !err_q); // R5
  AST_BAD_WARP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !warp_ok) |=> err_q); // R6
  AST_HANDSHAKE_OPEN: assert property (@(posedge clk)
    cfg_valid |-> cfg_ready); // R9
endmodule

// File: tb/grp_barrier_unit_tb.sv
module grp_barrier_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, arr_valid = 1'b0;
  logic [2:0]  cfg_slot = '0, arr_slot = '0;
  logic [9:0]  cfg_threads = '0;
  logic [4:0]  arr_warp = '0;
  logic        cfg_ready, arr_ready, arrive_err;
  logic [23:0] stall_mask;
  logic [7:0]  release_pulse;

  int checks = 0, fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  grp_barrier_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_slot(cfg_slot),
    .cfg_threads(cfg_threads),
    .arr_valid(arr_valid), .arr_ready(arr_ready), .arr_slot(arr_slot),
    .arr_warp(arr_warp),
    .stall_mask(stall_mask), .release_pulse(release_pulse),
    .arrive_err(arrive_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic configure(input int s, input int t);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_slot = 3'(s); cfg_threads = 10'(t);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic arrive(input int s, input int w);
    @(negedge clk);
    arr_valid = 1'b1; arr_slot = 3'(s); arr_warp = 5'(w);
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic both(input int s, input int t, input int w);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_slot = 3'(s); cfg_threads = 10'(t);
    arr_valid = 1'b1; arr_slot = 3'(s); arr_warp = 5'(w);
    @(negedge clk);
    cfg_valid = 1'b0; arr_valid = 1'b0;
  endtask

  // monitor: every release pulse must match the next expected slot
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int s = 0; s < 8; s++) begin
        if (release_pulse[s]) begin
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected release", 32'(s), 32'hFFFF);
          else begin
            int e;
            e = exp_q.pop_front();
            eq("R3 release slot", 32'(s), 32'(e));
          end
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    eq("R10 stall after reset", 32'(stall_mask), 0);
    eq("R10 release after reset", 32'(release_pulse), 0);
    eq("R10 err after reset", 32'(arrive_err), 0);
    eq("R9 ready in reset", 32'({cfg_ready, arr_ready}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    eq("R10 stall idle", 32'(stall_mask), 0);

    // R1/R2/R3: 64 threads -> two warps
    configure(0, 64);
    arrive(0, 3);
    eq("R2 stall bit 3", 32'(stall_mask), 32'h8);
    eq("R3 no early release", 32'(release_pulse), 0);
    exp_q.push_back(0);
    arrive(0, 5);
    eq("R3 mask cleared", 32'(stall_mask), 0);
    eq("R3 pulse slot0", 32'(release_pulse), 32'h1);
    @(negedge clk);
    eq("R3 pulse one cycle", 32'(release_pulse), 0);
    eq("R9 ready open", 32'({cfg_ready, arr_ready}), 3);

    // R1 rounding: 33 threads -> 2 warps, 32 threads -> 1 warp
    configure(2, 33);
    arrive(2, 0);
    eq("R1 33 threads holds", 32'(stall_mask), 32'h1);
    exp_q.push_back(2);
    arrive(2, 1);
    eq("R1 33 threads releases", 32'(stall_mask), 0);
    configure(6, 32);
    exp_q.push_back(6);
    arrive(6, 9);
    eq("R3 single warp never stalls", 32'(stall_mask), 0);
    eq("R1 32 threads pulse", 32'(release_pulse), 32'h40);

    // R5 re-arrival
    configure(1, 96);
    arrive(1, 7);
    arrive(1, 7);
    eq("R5 err on repeat", 32'(arrive_err), 1);
    eq("R5 mask unchanged", 32'(stall_mask), 32'h80);
    eq("R5 no release", 32'(release_pulse), 0);
    arrive(1, 8);
    eq("R5 err clears", 32'(arrive_err), 0);
    eq("R5 count not bumped", 32'(stall_mask), 32'h180);
    exp_q.push_back(1);
    arrive(1, 9);
    eq("R5 release after third", 32'(stall_mask), 0);

    // R4 interleaved slots
    configure(3, 64);
    configure(4, 64);
    arrive(3, 10);
    arrive(4, 12);
    eq("R4 two slots held", 32'(stall_mask), 32'h1400);
    exp_q.push_back(3);
    arrive(3, 11);
    eq("R4 other slot kept", 32'(stall_mask), 32'h1000);
    exp_q.push_back(4);
    arrive(4, 13);
    eq("R4 both released", 32'(stall_mask), 0);

    // R7 termination, then R6 inactive slot
    configure(5, 128);
    arrive(5, 14);
    arrive(5, 15);
    eq("R7 held before end", 32'(stall_mask), 32'hC000);
    configure(5, 0);
    eq("R7 end clears", 32'(stall_mask), 0);
    eq("R7 no pulse", 32'(release_pulse), 0);
    arrive(5, 14);
    eq("R6 inactive err", 32'(arrive_err), 1);
    eq("R6 inactive ignored", 32'(stall_mask), 0);

    // R6 warp out of range, slot 0 still needs two warps
    arrive(0, 24);
    eq("R6 range err", 32'(arrive_err), 1);
    eq("R6 range ignored", 32'(stall_mask), 0);
    arrive(0, 2);
    eq("R6 count unaffected", 32'(stall_mask), 32'h4);
    exp_q.push_back(0);
    arrive(0, 4);
    eq("R3 slot reuse", 32'(stall_mask), 0);

    // R8 configure beats arrival in same cycle
    both(2, 64, 20);
    eq("R8 arrival dropped", 32'(stall_mask), 0);
    eq("R8 no err", 32'(arrive_err), 0);
    arrive(2, 20);
    eq("R8 fresh count", 32'(stall_mask), 32'h100000);
    exp_q.push_back(2);
    arrive(2, 21);
    eq("R8 then release", 32'(stall_mask), 0);

    // R1 maximum group: 512 threads -> 16 warps
    configure(7, 512);
    for (int w = 0; w < 15; w++) arrive(7, w);
    eq("R1 fifteen held", 32'(stall_mask), 32'h7FFF);
    eq("R1 no early release", 32'(release_pulse), 0);
    exp_q.push_back(7);
    arrive(7, 15);
    eq("R1 sixteen releases", 32'(stall_mask), 0);

    repeat (2) @(negedge clk);
    eq("R3 all releases seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule